// File: doc/BRIEF.md
# Periodic Hub Access Window Scheduler

This block gives one processor core timed access to a shared memory hub. A down-counter with a reload register opens a one-clock access window once every N clocks. N is programmable, may be any value from 2 to 31, and need not be a power of two. When the core raises a request, it is held stalled until the next window opens. At that window the block drives a single-port memory interface. A write retires in the window cycle itself. A read retires two clocks later, and its formatted data is presented at the same moment as the completion pulse.

The core presents a read/write flag, a byte-or-word size, a byte address and write data. It keeps all of them steady until the block pulses `done_o`. The core freezes its pipeline on `stall_o`. Byte writes are turned into a single-lane write with a lane mask. Byte reads return the addressed lane, zero-extended.

Top module: `hub_window_sched`

## Requirements
- R1: After reset the window (`win_o`) is open in the first cycle after reset release and then every 16 clocks. During reset `done_o` and `stall_o` are low and `rdata_o` is zero.
- R2: After a period value P in 2..31 is loaded, consecutive windows are exactly P clocks apart. This includes values that are not powers of two, such as 3, 14 and 20.
- R3: Period values 0 and 1 give a window spacing of 2 clocks.
- R4: A period written between windows leaves the interval in progress at its old length. The new spacing starts with the interval that follows the next window.
- R5: A write raised d clocks before a window (d = 0 when raised in a window cycle) keeps `stall_o` high for exactly d cycles. It pulses `done_o` in the window cycle.
- R6: A read raised d clocks before a window keeps `stall_o` high for exactly d+2 cycles. `done_o` and valid `rdata_o` appear 2 clocks after the window.
- R7: With a period of 2, a write raised on an even offset from a window never stalls, and a read stalls for exactly 2 clocks.
- R8: `stall_o` is high exactly when `req_i` is high and `done_o` is low. It is low whenever no request is present.
- R9: A byte write (`size_long_i`=0) enables only lane `addr_i[1:0]` (bit k of `mem_be_o` covers `mem_wdata_o[8k+7:8k]`), carrying `wdata_i[7:0]` on that lane. A word write enables all four lanes.
- R10: A byte read returns the byte of lane `addr_i[1:0]` in `rdata_o[7:0]` with the upper bits zero. A word read returns the whole memory word.
- R11: Each request produces exactly one memory access (`mem_en_o` high for one cycle). Access cycles are never back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Load `cfg_period_i` as the pending period |
| cfg_period_i | input | PER_W | New window period in clocks |
| req_i | input | 1 | Core access request, held until `done_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| size_long_i | input | 1 | 1 = full word, 0 = single byte |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data (byte in bits 7:0) |
| stall_o | output | 1 | Core must hold its pipeline |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Read result, valid with `done_o` |
| win_o | output | 1 | Access window open this cycle |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W-log2(DATA_W/8) | Memory word address |
| mem_be_o | output | DATA_W/8 | Memory byte lane enables |
| mem_wdata_o | output | DATA_W | Lane-aligned write data |
| mem_rdata_i | input | DATA_W | Memory read data, registered one clock after `mem_en_o` |

## Verification
The assertions assume that the core holds `req_i`, `we_i`, `size_long_i`, `addr_i` and `wdata_i` unchanged from the cycle it raises a request until the cycle `done_o` pulses. They also assume the core drops `req_i` in the following cycle. The checks on read latency and single access further assume memory data returns one clock after the strobe. The bench drives every request through one task that holds the fields for the whole stall and releases the request right after completion. Its memory model registers read data on the strobe edge, so the stimulus stays inside those assumptions.

// File: rtl/hws_pkg.sv
package hws_pkg;

  // Smallest legal window spacing: one instruction cycle of two clocks.
  localparam int unsigned MIN_PERIOD = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_FETCH,
    ST_RD_RET
  } acc_state_e;

  // Clamp a programmed period to the legal floor.
  function automatic int unsigned eff_period(input int unsigned raw);
    return (raw < MIN_PERIOD) ? MIN_PERIOD : raw;
  endfunction

endpackage

// File: rtl/hws_slot_timer.sv
module hws_slot_timer #(
  parameter int PER_W      = 5,
  parameter int DEF_PERIOD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic [PER_W-1:0] cfg_period_i,
  output logic             win_o
);

  localparam logic [PER_W-1:0] RST_PERIOD = PER_W'(hws_pkg::eff_period(DEF_PERIOD));

  logic [PER_W-1:0] pend_q;   // last written period
  logic [PER_W-1:0] act_q;    // period of the interval in progress
  logic [PER_W-1:0] cnt_q;    // clocks left until the next window
  logic [PER_W-1:0] eff_next;
  logic             win;

  always_comb begin
    eff_next = PER_W'(hws_pkg::eff_period(32'(pend_q)));
    win      = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RST_PERIOD;
      act_q  <= RST_PERIOD;
      cnt_q  <= '0;
    end else begin
      if (cfg_wr_i) pend_q <= cfg_period_i;
      if (win) begin
        act_q <= eff_next;
        cnt_q <= eff_next - 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign win_o = win;

  // R2
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_q);

  // R3
  no_back_to_back_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win |=> !win);

  // R4
  period_held_mid_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win |=> $stable(act_q));

endmodule

// File: rtl/hws_access_fsm.sv
module hws_access_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic win_i,
  input  logic req_i,
  input  logic we_i,
  output logic fire_o,
  output logic wr_done_o,
  output logic rd_capture_o,
  output logic rd_done_o
);

  import hws_pkg::*;

  acc_state_e state_q, state_d;
  logic       fire;

  always_comb begin
    fire    = win_i && req_i && (state_q == ST_IDLE);
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (fire && !we_i) state_d = ST_RD_FETCH;
      ST_RD_FETCH: state_d = ST_RD_RET;
      ST_RD_RET:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign fire_o       = fire;
  assign wr_done_o    = fire && we_i;
  assign rd_capture_o = (state_q == ST_RD_FETCH);
  assign rd_done_o    = (state_q == ST_RD_RET);

  // R6
  rd_fetch_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !we_i) |=> rd_capture_o);

  // R6
  rd_done_follows_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture_o |=> rd_done_o);

  // R11
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

endmodule

// File: rtl/hws_lane_unit.sv
module hws_lane_unit #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   size_long_i,
  input  logic [ADDR_W-1:0]                      addr_i,
  input  logic [DATA_W-1:0]                      wdata_i,
  input  logic [DATA_W-1:0]                      mem_rdata_i,
  input  logic                                   capture_i,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     mem_addr_o,
  output logic [DATA_W/8-1:0]                    mem_be_o,
  output logic [DATA_W-1:0]                      mem_wdata_o,
  output logic [DATA_W-1:0]                      rdata_o
);

  localparam int LANES = DATA_W / 8;
  localparam int LSB_W = $clog2(LANES);

  logic [LSB_W-1:0]  lane_sel;
  logic [7:0]        byte_pick;
  logic [DATA_W-1:0] rd_fmt;
  logic [DATA_W-1:0] rdata_q;

  assign lane_sel   = addr_i[LSB_W-1:0];
  assign mem_addr_o = addr_i[ADDR_W-1:LSB_W];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mem_be_o[g]          = size_long_i || (lane_sel == LSB_W'(g));
    assign mem_wdata_o[g*8 +: 8] = size_long_i ? wdata_i[g*8 +: 8] : wdata_i[7:0];
  end

  always_comb begin
    byte_pick = mem_rdata_i[{lane_sel, 3'b000} +: 8];
    rd_fmt    = size_long_i ? mem_rdata_i : {{(DATA_W-8){1'b0}}, byte_pick};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (capture_i) rdata_q <= rd_fmt;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/hub_window_sched.sv
module hub_window_sched #(
  parameter int PER_W      = 5,
  parameter int DEF_PERIOD = 16,
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_wr_i,
  input  logic [PER_W-1:0]                   cfg_period_i,
  input  logic                               req_i,
  input  logic                               we_i,
  input  logic                               size_long_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic                               stall_o,
  output logic                               done_o,
  output logic [DATA_W-1:0]                  rdata_o,
  output logic                               win_o,
  output logic                               mem_en_o,
  output logic                               mem_we_o,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr_o,
  output logic [DATA_W/8-1:0]                mem_be_o,
  output logic [DATA_W-1:0]                  mem_wdata_o,
  input  logic [DATA_W-1:0]                  mem_rdata_i
);

  logic win, fire, wr_done, rd_capture, rd_done;

  hws_slot_timer #(
    .PER_W      (PER_W),
    .DEF_PERIOD (DEF_PERIOD)
  ) timer_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_period_i (cfg_period_i),
    .win_o        (win)
  );

  hws_access_fsm fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_i        (win),
    .req_i        (req_i),
    .we_i         (we_i),
    .fire_o       (fire),
    .wr_done_o    (wr_done),
    .rd_capture_o (rd_capture),
    .rd_done_o    (rd_done)
  );

  hws_lane_unit #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) lane_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .size_long_i (size_long_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .mem_rdata_i (mem_rdata_i),
    .capture_i   (rd_capture),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o),
    .rdata_o     (rdata_o)
  );

  assign win_o    = win;
  assign mem_en_o = fire;
  assign mem_we_o = wr_done;
  assign done_o   = wr_done || rd_done;
  assign stall_o  = req_i && !done_o;

  // R9
  byte_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !size_long_i) |-> ($countones(mem_be_o) == 1));

  // R5
  write_retires_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && we_i) |-> (done_o && win_o));

  // R11
  no_access_while_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !we_i) |-> !mem_en_o);

endmodule

// File: tb/hub_window_sched_tb_top.sv
`timescale 1ns/1ps
module hub_window_sched_tb_top;

  localparam int PER_W  = 5;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int WORDS  = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_wr;
  logic [PER_W-1:0]  cfg_period;
  logic              req, we, size_long;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic              stall, done, win, mem_en, mem_we;
  logic [DATA_W-1:0] rdata, mem_wdata;
  logic [5:0]        mem_addr;
  logic [3:0]        mem_be;
  logic [DATA_W-1:0] mem_rdata;

  logic [31:0] mem [WORDS];
  logic [31:0] shadow [WORDS];
  int          en_cnt;
  int          cyc;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  hub_window_sched #(
    .PER_W (PER_W), .DEF_PERIOD (16), .ADDR_W (ADDR_W), .DATA_W (DATA_W)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .cfg_wr_i (cfg_wr), .cfg_period_i (cfg_period),
    .req_i (req), .we_i (we), .size_long_i (size_long), .addr_i (addr),
    .wdata_i (wdata), .stall_o (stall), .done_o (done), .rdata_o (rdata),
    .win_o (win), .mem_en_o (mem_en), .mem_we_o (mem_we), .mem_addr_o (mem_addr),
    .mem_be_o (mem_be), .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata)
  );

  // Single-port memory: read data registered on the strobe edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      mem_rdata <= '0;
      en_cnt    <= 0;
    end else if (mem_en) begin
      en_cnt    <= en_cnt + 1;
      mem_rdata <= mem[mem_addr];
      for (int l = 0; l < 4; l++)
        if (mem_we && mem_be[l]) mem[mem_addr][l*8 +: 8] <= mem_wdata[l*8 +: 8];
    end
  end

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_win();
    do begin @(negedge clk); #1; end while (!win);
  endtask

  task automatic set_period(input int v);
    @(negedge clk); cfg_wr = 1'b1; cfg_period = PER_W'(v);
    @(negedge clk); cfg_wr = 1'b0;
    #1;
    wait_win();
  endtask

  task automatic spacing(output int gap);
    wait_win();
    gap = 0;
    do begin @(negedge clk); #1; gap++; end while (!win);
  endtask

  task automatic access(input bit w, input bit lng, input int a, input logic [31:0] d,
                        output int stalls, output logic [31:0] rd, output int ens);
    int e0;
    e0 = en_cnt;
    stalls = 0;
    @(negedge clk);
    req = 1'b1; we = w; size_long = lng; addr = ADDR_W'(a); wdata = d;
    #1;
    while (!done) begin
      check(stall == 1'b1, "R8 stall while pending", stall, 1);
      stalls++;
      @(negedge clk); #1;
    end
    check(stall == 1'b0, "R8 stall in done cycle", stall, 0);
    rd = rdata;
    @(negedge clk);
    req = 1'b0;
    #1;
    check(stall == 1'b0, "R8 stall without request", stall, 0);
    ens = en_cnt - e0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int gap;
    int periods [8] = '{2, 4, 8, 14, 16, 20, 3, 31};
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_period = '0; req = 1'b0; we = 1'b0;
    size_long = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < WORDS; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(stall == 1'b0, "R1 stall in reset", stall, 0);
    check(rdata == '0, "R1 rdata in reset", rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 default 16-clock window spacing from reset release
    for (int i = 0; i < 40; i++) begin
      #1;
      check(win == ((cyc % 16) == 0), "R1 default window", win, (cyc % 16) == 0);
      check(stall == 1'b0, "R8 idle stall", stall, 0);
      @(negedge clk);
    end

    // R4 mid-interval write keeps the current interval
    wait_win();
    @(negedge clk); cfg_wr = 1'b1; cfg_period = 5'd6;
    #1; gap = 1;
    @(negedge clk); cfg_wr = 1'b0;
    #1; gap = 2;
    while (!win) begin @(negedge clk); #1; gap++; end
    check(gap == 16, "R4 interval in progress", gap, 16);
    gap = 0;
    do begin @(negedge clk); #1; gap++; end while (!win);
    check(gap == 6, "R4 new interval", gap, 6);

    // R3 clamp of 0 and 1
    for (int v = 0; v < 2; v++) begin
      set_period(v);
      spacing(gap);
      check(gap == 2, "R3 clamped period", gap, 2);
    end

    // Sweep periods and request offsets
    foreach (periods[pi]) begin
      int p;
      p = periods[pi];
      set_period(p);
      spacing(gap);
      check(gap == p, "R2 window spacing", gap, p);
      for (int k = 1; k <= p; k++) begin
        int          dly, st, ens, word, lane, a;
        bit          lng;
        logic [31:0] d, rd, exp;
        dly  = (p - (k % p)) % p;
        word = (k * 7 + p) % WORDS;
        lane = k % 4;
        lng  = (k % 3) != 0;
        a    = word * 4 + lane;
        d    = 32'hA500_0000 ^ (32'(p) << 16) ^ (32'(k) * 32'h0000_0103);
        // write
        wait_win();
        repeat (k - 1) @(negedge clk);
        access(1'b1, lng, a, d, st, rd, ens);
        if (lng) shadow[word] = d;
        else     shadow[word][lane*8 +: 8] = d[7:0];
        if (p == 2) check(st == dly, "R7 write stall at period 2", st, dly);
        else        check(st == dly, "R5 write stall", st, dly);
        check(ens == 1, "R11 accesses per write", ens, 1);
        check(mem[word] == shadow[word], "R9 memory lanes after write", mem[word], shadow[word]);
        // read
        wait_win();
        repeat (k - 1) @(negedge clk);
        access(1'b0, lng, a, 32'hDEAD_BEEF, st, rd, ens);
        exp = lng ? shadow[word] : {24'h0, shadow[word][lane*8 +: 8]};
        if (p == 2) check(st == dly + 2, "R7 read stall at period 2", st, dly + 2);
        else        check(st == dly + 2, "R6 read stall", st, dly + 2);
        check(rd == exp, "R10 read data", rd, exp);
        check(ens == 1, "R11 accesses per read", ens, 1);
        check(mem[word] == shadow[word], "R9 read leaves memory", mem[word], shadow[word]);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule